// File: doc/BRIEF.md
# Byte-Lane Data Breakpoint Comparator

This block watches a 32-bit local data bus and raises a trigger when a chosen part of the bus matches a stored breakpoint value. Seven separate lane comparators are available: one covers the whole longword, two cover the 16-bit halves and four cover the single bytes. Each comparator has its own enable bit. A single global invert bit turns every comparator around, so the block can also fire when the selected data differs from the stored value.

Software loads the breakpoint value and the control word through a simple register write port. A select line picks the target register. The bus side offers data together with a transfer-valid strobe. The trigger output is registered. It is high in the cycle after a valid transfer in which at least one enabled comparator, after inversion, reports a hit.

Top module: `dbrk_lane_cmp`

## Requirements
- R1: After a synchronous active-low reset, the trigger output is 0 and the breakpoint data register and the control register are both cleared to 0.
- R2: When control bit 12 is set, the comparator covering the whole bus (bits 31:0) hits when all 32 bus bits equal the breakpoint register.
- R3: When control bit 11 is set, the comparator on bus bits 15:0 hits when they equal the same bits of the breakpoint register. Control bit 10 does the same for bits 31:16.
- R4: Control bits 9, 8, 7 and 6 enable the byte comparators for bus bits 7:0, 15:8, 23:16 and 31:24 in that order.
- R5: When control bits 12:6 are all clear, no trigger is produced, whatever the invert bit, the bus data or the strobe.
- R6: When control bit 5 (invert) is set, every enabled comparator reports a hit when its lane differs from the breakpoint register instead of when it matches.
- R7: The trigger is the OR of all enabled comparator results after inversion. A lane that matches while another enabled lane does not is enough to fire.
- R8: A comparison only counts in a cycle where bus_valid is high. The trigger is registered and appears in the cycle after the sampled transfer. In every other cycle it is 0.
- R9: Each comparator looks only at the bits of its own lane. Bus bits outside every enabled lane have no effect on the trigger.
- R10: A write with cfg_wr_sel = 0 loads the breakpoint data register. A write with cfg_wr_sel = 1 loads control bits 12:5 from the write data. A new value takes effect for transfers sampled after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | 0 selects the breakpoint data register, 1 selects the control register |
| cfg_wr_data | input | 32 | Write data |
| bus_valid | input | 1 | Transfer-valid strobe for the data bus |
| bus_data | input | 32 | Local data bus value |
| trig_o | output | 1 | Registered data breakpoint trigger |

## Verification
Each comparator is tried on its own with three kinds of bus value: an exact match, a value that matches only inside the lane, and a value that differs by one bit inside the lane. Together these show that the lane boundary is right and that bits outside the lane are ignored. Pairs of byte enables are tried with one lane matching and with no lane matching, which separates the OR of the lanes from an AND. The same patterns are repeated with the invert bit set, with every enable clear and with the strobe low. These runs keep apart inversion, the disabled state and the gating by the strobe. Directed runs after a reset check the cleared registers and the one-cycle trigger latency.

// File: rtl/dbk_pkg.sv
// Package: shared constants and lane geometry for the data breakpoint block.
// Assumes a 32-bit bus; lane k is enabled by control bit EN_LSB+k.
package dbk_pkg;
    localparam int BUS_W   = 32;
    localparam int LANES   = 7;
    localparam int EN_LSB  = 6;
    localparam int INV_BIT = 5;
    localparam int CTL_MSB = EN_LSB + LANES - 1;

    typedef struct packed {
        logic [LANES-1:0] en;
        logic             inv;
    } dbk_cfg_t;

    // Lowest bus bit of lane k: k=0..3 bytes 31:24 down to 7:0, k=4 upper word, k=5 lower word, k=6 longword.
    function automatic int lane_lo(input int k);
        if (k < 4)       return (3 - k) * 8;
        else if (k == 4) return 16;
        else             return 0;
    endfunction

    // Width in bits of lane k.
    function automatic int lane_w(input int k);
        if (k < 4)      return 8;
        else if (k < 6) return 16;
        else            return 32;
    endfunction
endpackage

// File: rtl/dbk_cfg_regs.sv
// Module: holds the breakpoint data register and the control fields.
// Assumes single-cycle writes; a written value is visible from the next cycle on.
module dbk_cfg_regs
    import dbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] bp_data,
    output dbk_cfg_t         cfg
);
    // Breakpoint data register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bp_data <= '0;
        else if (wr_en && !wr_sel)  bp_data <= wr_data;
    end

    // Control field update: enables and invert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && wr_sel) begin
            cfg.en  <= wr_data[CTL_MSB:EN_LSB];
            cfg.inv <= wr_data[INV_BIT];
        end
    end

    p_data_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (bp_data == $past(wr_data)));

    p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (cfg.en == $past(wr_data[CTL_MSB:EN_LSB])));
endmodule

// File: rtl/dbk_lane_cmp.sv
// Module: equality comparator over one bus lane.
// Assumes LO+W fits inside the bus; only that slice of both operands is examined.
module dbk_lane_cmp
    import dbk_pkg::*;
#(
    parameter int LO = 0,
    parameter int W  = 8
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] ref_val,
    input  logic             en,
    input  logic             inv,
    output logic             hit
);
    logic same;

    // Lane equality, then invert and enable gating.
    always_comb begin
        same = (bus[LO +: W] == ref_val[LO +: W]);
        hit  = en & (same ^ inv);
    end
endmodule

// File: rtl/dbk_trig_reg.sv
// Module: combines lane results and registers the trigger.
// Assumes lane hits are already gated by their enables.
module dbk_trig_reg
    import dbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [LANES-1:0] hits,
    output logic             trig
);
    // Trigger register: OR of lanes, only on valid transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= valid & (|hits);
    end

    p_no_trig_without_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !trig);
endmodule

// File: rtl/dbrk_lane_cmp.sv
// Module: top of the byte-lane data breakpoint comparator.
// Assumes the register port and the bus share one clock; the trigger lags the sample by one cycle.
module dbrk_lane_cmp
    import dbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_wr_sel,
    input  logic [BUS_W-1:0] cfg_wr_data,
    input  logic             bus_valid,
    input  logic [BUS_W-1:0] bus_data,
    output logic             trig_o
);
    logic [BUS_W-1:0] bp_data;
    dbk_cfg_t         cfg;
    logic [LANES-1:0] hits;

    dbk_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .bp_data (bp_data),
        .cfg     (cfg)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dbk_lane_cmp #(
            .LO (lane_lo(k)),
            .W  (lane_w(k))
        ) u_cmp (
            .bus     (bus_data),
            .ref_val (bp_data),
            .en      (cfg.en[k]),
            .inv     (cfg.inv),
            .hit     (hits[k])
        );
    end

    dbk_trig_reg u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (bus_valid),
        .hits  (hits),
        .trig  (trig_o)
    );

    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en == '0) |=> !trig_o);

    p_trig_from_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(bus_valid));

    p_long_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && cfg.en[LANES-1] && !cfg.inv && bus_data == bp_data) |=> trig_o);
endmodule

// File: tb/test_dbrk_lane_cmp.sv
module test_dbrk_lane_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_data = '0;
    logic        trig_o;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    dbrk_lane_cmp i_dbrk_lane_cmp (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .bus_valid(bus_valid), .bus_data(bus_data), .trig_o(trig_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] ctrl;
        logic [31:0] bp;
        logic        vld;
        logic [31:0] bus;
        logic        exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [0:NV-1] = '{
        '{8'd2,  32'h0000_1000, 32'h1234_5678, 1'b1, 32'h1234_5678, 1'b1}, // R2 exact
        '{8'd2,  32'h0000_1000, 32'h1234_5678, 1'b1, 32'h1234_5679, 1'b0}, // R2 one bit off
        '{8'd9,  32'h0000_0800, 32'h1234_5678, 1'b1, 32'hFFFF_5678, 1'b1}, // R3/R9 lower word
        '{8'd3,  32'h0000_0400, 32'h1234_5678, 1'b1, 32'h1234_0000, 1'b1}, // R3 upper word
        '{8'd3,  32'h0000_0400, 32'h1234_5678, 1'b1, 32'h1235_5678, 1'b0}, // R3 upper miss
        '{8'd9,  32'h0000_0200, 32'h1234_5678, 1'b1, 32'hAAAA_AA78, 1'b1}, // R4/R9 byte 7:0
        '{8'd4,  32'h0000_0100, 32'h1234_5678, 1'b1, 32'h0000_5600, 1'b1}, // R4 byte 15:8
        '{8'd4,  32'h0000_0080, 32'h1234_5678, 1'b1, 32'h0034_0000, 1'b1}, // R4 byte 23:16
        '{8'd4,  32'h0000_0040, 32'h1234_5678, 1'b1, 32'h1200_0000, 1'b1}, // R4 byte 31:24
        '{8'd4,  32'h0000_0040, 32'h1234_5678, 1'b1, 32'h1334_5678, 1'b0}, // R4 byte 31:24 miss
        '{8'd6,  32'h0000_1020, 32'h1234_5678, 1'b1, 32'h1234_5678, 1'b0}, // R6 invert, match
        '{8'd6,  32'h0000_1020, 32'h1234_5678, 1'b1, 32'h0000_0000, 1'b1}, // R6 invert, differ
        '{8'd7,  32'h0000_0240, 32'h1234_5678, 1'b1, 32'h1200_0000, 1'b1}, // R7 one of two lanes
        '{8'd7,  32'h0000_0240, 32'h1234_5678, 1'b1, 32'h0000_0000, 1'b0}, // R7 no lane
        '{8'd5,  32'h0000_0000, 32'h1234_5678, 1'b1, 32'h1234_5678, 1'b0}, // R5 all clear
        '{8'd5,  32'h0000_0020, 32'h1234_5678, 1'b1, 32'h0000_0000, 1'b0}, // R5 invert only
        '{8'd8,  32'h0000_1000, 32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0}, // R8 strobe low
        '{8'd6,  32'h0000_0320, 32'h1234_5678, 1'b1, 32'h0000_5678, 1'b0}, // R6 both lanes match
        '{8'd6,  32'h0000_0320, 32'h1234_5678, 1'b1, 32'h0000_5600, 1'b1}, // R6 low byte differs
        '{8'd9,  32'h0000_0100, 32'hFFFF_00FF, 1'b1, 32'h0000_0000, 1'b1}  // R9 outside bits ignored
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s trig_o actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Present one transfer; return the trigger one cycle later.
    task automatic probe(input logic v, input logic [31:0] d, output logic t);
        @(negedge clk);
        bus_valid = v; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_data = '0;
        t = trig_o;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic t;
        repeat (3) @(negedge clk);
        check("R1 reset trig", trig_o, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            reg_write(1'b0, VEC[i].bp);
            reg_write(1'b1, VEC[i].ctrl);
            probe(VEC[i].vld, VEC[i].bus, t);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), t, VEC[i].exp);
        end

        // R1: control cleared by reset (data written, matching bus, no trigger)
        reg_write(1'b1, 32'h0000_1000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 trig after reset", trig_o, 1'b0);
        reg_write(1'b0, 32'h0000_0000);
        probe(1'b1, 32'h0000_0000, t);
        check("R1 control cleared", t, 1'b0);
        // R1: data register cleared by reset
        reg_write(1'b0, 32'hDEAD_BEEF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_write(1'b1, 32'h0000_1000);
        probe(1'b1, 32'h0000_0000, t);
        check("R1 data cleared", t, 1'b1);

        // R8: one-cycle latency and single pulse
        @(negedge clk);
        bus_valid = 1'b1; bus_data = 32'h0000_0000;
        check("R8 not yet registered", trig_o, 1'b0);
        @(negedge clk);
        bus_valid = 1'b0; bus_data = 32'h0000_0000;
        check("R8 trigger next cycle", trig_o, 1'b1);
        @(negedge clk);
        check("R8 pulse ends", trig_o, 1'b0);

        // R10: new control applies only after its edge
        reg_write(1'b0, 32'hCAFE_0000);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 1'b1; cfg_wr_data = 32'h0000_0000;
        bus_valid = 1'b1; bus_data = 32'hCAFE_0000;
        @(negedge clk);
        cfg_wr_en = 1'b0; bus_valid = 1'b0;
        check("R10 old control used in write cycle", trig_o, 1'b1);
        probe(1'b1, 32'hCAFE_0000, t);
        check("R10 new control applies", t, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule